// File: doc/BRIEF.md
# Watchdog and Longdog Supervision Timer

This block supervises a host with two timers that share one service input. The short timer (watchdog) asks for an interrupt when the host fails to service it in time. The long timer (longdog) asks for a system reset when the host stays silent for a much longer span. Both timers restart at the same moment on a rising edge of the service pin, or on a one-cycle software service strobe.

Time is counted in ticks of an external time base. One timeout unit equals `UNIT_TICKS` ticks. A 3-bit code selects the watchdog length and a 2-bit code selects the longdog length. Both fields have an "off" value. When the longdog expires, its reset request stays high until the host services the timers or the reset logic reports that the reset has been released. While the request is high, both timers stay at zero. They start again from zero when the request drops.

The block does not stretch reset pulses, latch interrupts or drive output pins. The reset/interrupt logic that follows it handles all of that.

Top module: `wdldSupervisor`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `wdIrq` and `ldRstReq` are 0 and both timers are at zero.
- R2: A 0-to-1 change of `svcPin` clears both timers on the clock edge where the change is first seen. Holding `svcPin` at 1 afterwards does not clear them again, so a longdog of N ticks still fires N ticks after that edge.
- R3: A high `swSvc` clears both timers on that clock edge, exactly like a service edge. Strobes repeated faster than the watchdog period produce no interrupt.
- R4: Watchdog code `wdSel` values 1,2,3,4,5 give periods of 1,2,4,8,16 units. Values 0, 6 and 7 are off: that timer never expires and stays at zero.
- R5: Longdog code `ldSel` values 1,2,3 give periods of 4,8,16 units. Value 0 is off.
- R6: On the clock edge that takes the N-th tick after a clear, an enabled watchdog of N ticks raises `wdIrq` for one cycle and restarts from zero. Left unserviced, it fires again every N ticks.
- R7: If `svcPin` is 1 on the edge where the watchdog expires, no `wdIrq` pulse is produced, but the timer still restarts.
- R8: On the edge that takes the N-th tick of an enabled longdog of N ticks, `ldRstReq` goes to 1. It stays at 1, with both timers held at zero and no `wdIrq`, until a release event.
- R9: A service edge, `swSvc` or `rstReleased` drops `ldRstReq` on that edge. The timers then restart from zero, so the longdog fires again N ticks later.
- R10: A `rstReleased` pulse while no reset is pending also restarts both timers from zero.
- R11: A clear on the same edge as a tick wins, and that tick is not counted. If both timers expire on the same tick, only the longdog acts. A longdog no longer than the watchdog therefore never lets `wdIrq` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| svcPin | input | 1 | Service input; its rising edge clears both timers and its high level masks interrupts |
| swSvc | input | 1 | One-cycle software service strobe |
| rstReleased | input | 1 | Pulse from the reset logic when the reset output returns inactive |
| tick | input | 1 | Time-base enable; each high cycle advances the timers by one |
| wdSel | input | 3 | Watchdog length code |
| ldSel | input | 2 | Longdog length code |
| wdIrq | output | 1 | One-cycle watchdog interrupt request |
| ldRstReq | output | 1 | Longdog reset request level |

## Verification
Most internal faults in this block show up as a change in when an event happens, not in what the event is. A counter that is off by one, clears late or keeps counting through a tick will move the next `wdIrq` pulse or `ldRstReq` rise by a tick or more. A wrong period decode shows up as a wrong gap between pulses. A fault in the hold or release logic shows up as a reset request that drops at the wrong time, or as interrupts that appear while a reset is pending. The bench steps a behavioural model next to the design and compares both outputs every cycle. Any fault is therefore reported on the first cycle where an output goes wrong, which is at most one full timeout after the fault begins.

// File: rtl/wdldPkg.sv
package wdldPkg;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic clrAll;   // force both counters to zero this edge
    logic advance;  // one time-base tick elapsed
  } tmrStrobe_t;

  localparam int WD_SEL_W    = 3;
  localparam int LD_SEL_W    = 2;
  localparam int WD_TOP_CODE = 5;  // highest watchdog code that is enabled
  localparam int LD_BASE_SH  = 1;  // longdog code 1 -> shift of 2 (4 units)

endpackage

// File: rtl/wdldCounter.sv
module wdldCounter
  import wdldPkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrStrobe_t    strobe,
  input  logic          enable,
  input  logic [CW-1:0] limit,
  output logic          atEnd
);

  logic [CW-1:0] cnt;

  // limit is at least one tick whenever enable is high
  assign atEnd = enable && (cnt >= limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrAll || !enable) begin
      cnt <= '0;
    end else if (strobe.advance) begin
      cnt <= atEnd ? '0 : cnt + CW'(1);
    end
  end

  // R4: a timer selected off sits at zero
  a_r4_off_holds_zero : assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (cnt == '0));

  // R9: a clear strobe leaves the counter at zero
  a_r9_clear_zeroes : assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clrAll) |-> (cnt == '0));

endmodule

// File: rtl/wdldDatapath.sv
module wdldDatapath
  import wdldPkg::*;
#(
  parameter int UNIT_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strobe,
  input  logic [WD_SEL_W-1:0] wdSel,
  input  logic [LD_SEL_W-1:0] ldSel,
  output logic                wdAtEnd,
  output logic                ldAtEnd
);

  localparam int MAX_TICKS = UNIT_TICKS << 4;
  localparam int CW        = $clog2(MAX_TICKS + 1);
  localparam int NTMR      = 2;

  logic [NTMR-1:0] tEn;
  logic [NTMR-1:0] tEnd;
  logic [CW-1:0]   tLim [NTMR];

  // Period decode: index 0 is the watchdog, index 1 the longdog
  always_comb begin
    tEn[0]  = (wdSel != '0) && (wdSel <= WD_SEL_W'(WD_TOP_CODE));
    tLim[0] = tEn[0] ? (CW'(UNIT_TICKS) << (wdSel - WD_SEL_W'(1))) : '0;
    tEn[1]  = (ldSel != '0);
    tLim[1] = tEn[1] ? (CW'(UNIT_TICKS) << ({1'b0, ldSel} + 3'(LD_BASE_SH))) : '0;
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    wdldCounter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .enable (tEn[i]),
      .limit  (tLim[i]),
      .atEnd  (tEnd[i])
    );
  end

  assign wdAtEnd = tEnd[0];
  assign ldAtEnd = tEnd[1];

endmodule

// File: rtl/wdldCtrl.sv
module wdldCtrl
  import wdldPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       svcPin,
  input  logic       swSvc,
  input  logic       rstReleased,
  input  logic       tick,
  input  logic       wdAtEnd,
  input  logic       ldAtEnd,
  output tmrStrobe_t strobe,
  output logic       wdIrq,
  output logic       ldRstReq
);

  logic svcPrev;
  logic svcEdge;
  logic clearReq;
  logic ldFire;
  logic wdFire;

  assign svcEdge  = svcPin && !svcPrev;
  assign clearReq = svcEdge || swSvc || rstReleased;
  assign ldFire   = tick && ldAtEnd && !clearReq && !ldRstReq;
  assign wdFire   = tick && wdAtEnd && !clearReq && !ldRstReq && !ldFire;

  always_comb begin
    strobe.clrAll  = clearReq || ldFire || ldRstReq;
    strobe.advance = tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcPrev  <= 1'b1;
      wdIrq    <= 1'b0;
      ldRstReq <= 1'b0;
    end else begin
      svcPrev <= svcPin;
      wdIrq   <= wdFire && !svcPin;
      if (clearReq)    ldRstReq <= 1'b0;
      else if (ldFire) ldRstReq <= 1'b1;
    end
  end

  // R7: an interrupt never follows a cycle where the service pin was high
  a_r7_masked_when_high : assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> !$past(svcPin));

  // R8: no interrupt while a longdog reset is pending
  a_r8_no_irq_in_reset : assert property (@(posedge clk) disable iff (!rstN)
    ldRstReq |-> !wdIrq);

  // R6: interrupts only arise from a time-base tick
  a_r6_irq_on_tick : assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> $past(tick));

  // R8: reset request only rises on a tick
  a_r8_rise_on_tick : assert property (@(posedge clk) disable iff (!rstN)
    $rose(ldRstReq) |-> $past(tick));

  // R9: reset request drops only on a release event
  a_r9_release_cause : assert property (@(posedge clk) disable iff (!rstN)
    $fell(ldRstReq) |-> ($past(swSvc) || $past(rstReleased) ||
                         ($past(svcPin) && !$past(svcPin, 2))));

endmodule

// File: rtl/wdldSupervisor.sv
module wdldSupervisor
  import wdldPkg::*;
#(
  parameter int UNIT_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                svcPin,
  input  logic                swSvc,
  input  logic                rstReleased,
  input  logic                tick,
  input  logic [WD_SEL_W-1:0] wdSel,
  input  logic [LD_SEL_W-1:0] ldSel,
  output logic                wdIrq,
  output logic                ldRstReq
);

  tmrStrobe_t strobe;
  logic       wdAtEnd;
  logic       ldAtEnd;

  wdldCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .svcPin      (svcPin),
    .swSvc       (swSvc),
    .rstReleased (rstReleased),
    .tick        (tick),
    .wdAtEnd     (wdAtEnd),
    .ldAtEnd     (ldAtEnd),
    .strobe      (strobe),
    .wdIrq       (wdIrq),
    .ldRstReq    (ldRstReq)
  );

  wdldDatapath #(.UNIT_TICKS(UNIT_TICKS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdSel   (wdSel),
    .ldSel   (ldSel),
    .wdAtEnd (wdAtEnd),
    .ldAtEnd (ldAtEnd)
  );

  // R11: both outputs never start on the same edge
  a_r11_longdog_wins : assert property (@(posedge clk) disable iff (!rstN)
    !(wdIrq && $rose(ldRstReq)));

endmodule

// File: tb/tb_wdldSupervisor.sv
`timescale 1ns/1ps
module tb_wdldSupervisor;

  localparam int UNIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic svcPin = 1'b0;
  logic swSvc = 1'b0;
  logic rstReleased = 1'b0;
  logic tick = 1'b0;
  logic [2:0] wdSel = 3'd0;
  logic [1:0] ldSel = 2'd0;
  logic wdIrq;
  logic ldRstReq;

  always #2.5 clk = ~clk;

  wdldSupervisor #(.UNIT_TICKS(UNIT)) dut (
    .clk(clk), .rstN(rstN), .svcPin(svcPin), .swSvc(swSvc),
    .rstReleased(rstReleased), .tick(tick), .wdSel(wdSel), .ldSel(ldSel),
    .wdIrq(wdIrq), .ldRstReq(ldRstReq)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int  wdE = 0, ldE = 0;
  bit  mIrq = 0, mRst = 0, prevSvc = 1;

  function automatic int wdLen(input int c);
    return (c >= 1 && c <= 5) ? (UNIT << (c - 1)) : 0;
  endfunction
  function automatic int ldLen(input int c);
    return (c >= 1) ? (UNIT << (c + 1)) : 0;
  endfunction

  always @(posedge clk) begin
    bit clr, nIrq, wdX, ldX;
    int wl, ll;
    if (!rstN) begin
      wdE = 0; ldE = 0; mIrq = 0; mRst = 0; prevSvc = 1;
    end else begin
      clr  = (svcPin && !prevSvc) || swSvc || rstReleased;
      wl   = wdLen(wdSel);
      ll   = ldLen(ldSel);
      nIrq = 0;
      if (clr) begin
        mRst = 0; wdE = 0; ldE = 0;
      end else if (mRst) begin
        wdE = 0; ldE = 0;
      end else if (tick) begin
        ldX = (ll > 0) && (ldE + 1 >= ll);
        wdX = (wl > 0) && (wdE + 1 >= wl);
        if (ldX) begin
          mRst = 1; wdE = 0; ldE = 0;
        end else begin
          if (wdX) begin nIrq = !svcPin; wdE = 0; end
          else wdE = (wl > 0) ? wdE + 1 : 0;
          ldE = (ll > 0) ? ldE + 1 : 0;
        end
      end
      if (wl == 0) wdE = 0;
      if (ll == 0) ldE = 0;
      mIrq = nIrq;
      prevSvc = svcPin;
    end
  end

  // ---------------- stimulus / sampling ----------------
  int  tickDiv = 1, divCnt = 0, cyc = 0;
  bit  autoRel = 0;
  int  irqSeen = 0, rstRise = 0, lastIrqCyc = -1, prevIrqCyc = -1;
  bit  lastRst = 0, lastIrq = 0;

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic step(input bit sw = 0, input bit rel = 0);
    @(negedge clk);
    checks++;
    if (wdIrq !== mIrq || ldRstReq !== mRst) begin
      failures++;
      $display("FAIL %s: actual irq=%b rst=%b expected irq=%b rst=%b (cycle %0d)",
               tag, wdIrq, ldRstReq, mIrq, mRst, cyc);
    end
    if (wdIrq) begin irqSeen++; prevIrqCyc = lastIrqCyc; lastIrqCyc = cyc; end
    if (ldRstReq && !lastRst) rstRise++;
    lastIrq = wdIrq;
    lastRst = ldRstReq;
    cyc++;
    tick = (divCnt == 0);
    divCnt = (divCnt + 1) % tickDiv;
    swSvc = sw;
    rstReleased = rel || (autoRel && ldRstReq);
  endtask

  task automatic waitEvent(input bit wantRst, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!(wantRst ? lastRst : lastIrq) && n < 400);
  endtask

  initial begin
    int n, b, r;
    // R1 reset state
    tag = "R1";
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R1", int'(wdIrq) + int'(ldRstReq), 0);

    // R6 free-running watchdog, tick every third cycle
    tag = "R6";
    wdSel = 3'd1; ldSel = 2'd0; tickDiv = 3;
    step(1);
    repeat (60) step();
    chk("R6", lastIrqCyc - prevIrqCyc, 3 * UNIT);
    tickDiv = 1; divCnt = 0;

    // R4 watchdog period decode
    tag = "R4";
    for (int c = 2; c <= 5; c++) begin
      wdSel = 3'(c);
      step(1); step();
      waitEvent(0, n);
      chk("R4", n, UNIT << (c - 1));
    end
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 6 || c == 7) begin
        wdSel = 3'(c);
        step(1);
        b = irqSeen;
        repeat (80) step();
        chk("R4", irqSeen - b, 0);
      end
    end

    // R5 longdog period decode
    tag = "R5";
    wdSel = 3'd0;
    for (int c = 1; c <= 3; c++) begin
      ldSel = 2'(c);
      step(1); step();
      waitEvent(1, n);
      chk("R5", n, UNIT << (c + 1));
      step(0, 1); step();
    end

    // R8 hold while reset pending
    tag = "R8";
    wdSel = 3'd1; ldSel = 2'd1;
    step(1); step();
    waitEvent(1, n);
    chk("R8", n, 4 * UNIT);
    b = irqSeen;
    repeat (20) step();
    chk("R8", int'(ldRstReq), 1);
    chk("R8", irqSeen - b, 0);

    // R9 release by service edge, then R7 masking while held high
    tag = "R9";
    svcPin = 1'b1;
    step();
    chk("R9", int'(ldRstReq), 0);
    b = irqSeen;
    waitEvent(1, n);
    chk("R9", n, 4 * UNIT);
    chk("R7", irqSeen - b, 0);
    step(1); step();
    chk("R9", int'(ldRstReq), 0);
    waitEvent(1, n);
    step(0, 1); step();
    chk("R9", int'(ldRstReq), 0);
    svcPin = 1'b0;

    // R10 release pulse restarts timers with no reset pending
    tag = "R10";
    wdSel = 3'd3; ldSel = 2'd0;
    step(1);
    repeat (10) step();
    step(0, 1); step();
    waitEvent(0, n);
    chk("R10", n, 4 * UNIT);

    // R3 software service strobes keep the watchdog quiet
    tag = "R3";
    wdSel = 3'd1;
    step(1);
    b = irqSeen;
    repeat (10) begin step(1); step(); step(); end
    chk("R3", irqSeen - b, 0);

    // R2 edge clears, level does not
    tag = "R2";
    wdSel = 3'd0; ldSel = 2'd1;
    step(); step();
    repeat (7) step();
    svcPin = 1'b1;
    step();
    waitEvent(1, n);
    chk("R2", n, 4 * UNIT);
    step(0, 1); step();
    svcPin = 1'b0;

    // R11 short longdog never lets the watchdog fire
    tag = "R11";
    autoRel = 1; wdSel = 3'd5; ldSel = 2'd1;
    step(1);
    b = irqSeen; r = rstRise;
    repeat (200) step();
    chk("R11", irqSeen - b, 0);
    chk("R11", int'(rstRise - r >= 5), 1);
    wdSel = 3'd3;
    b = irqSeen;
    repeat (100) step();
    chk("R11", irqSeen - b, 0);
    autoRel = 0;
    step(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule